// File: doc/BRIEF.md
# Banked Decision-Vector Memory

This block stores the survivor decision vectors of a trellis decoder, one full vector per time step at one address. The storage is eight small dual-port banks of 64 words by 4 bits. The banks sit side by side, so the word is 4 to 32 bits wide in 4-bit steps. A width selector picks how many banks take part. A clock controller lets only the selected banks run, and every other bank keeps its contents untouched.

A single address generator turns the same storage into one of three kinds of memory. In queue mode, words come back in arrival order. In stack mode, the newest word comes back first, which suits a trace-back pass that walks the trellis backwards. In random mode, the caller gives explicit read and write addresses. Full and empty flags guard the queue and stack modes. Reads are synchronous: data and a valid strobe appear one cycle after an accepted read request.

Top module: `decision_mem`

## Requirements
- R1: The word width is 4*(widthSel+1) bits. An accepted write stores wrData bits [4*(widthSel+1)-1:0] at one address, as one vector.
- R2: bankEnable[b] is 1 exactly when b <= widthSel. A bank whose enable is low takes no write, so its contents stay unchanged.
- R3: rdData bits at positions 4*(widthSel+1) and above always read 0.
- R4: With modeSel=2'b00 (queue), words are read back in the order they were written. The read and write pointers wrap modulo 64.
- R5: With modeSel=2'b01 (stack), a read returns the most recently written word that has not yet been read.
- R6: With modeSel[1]=1 (random, 2'b10 or 2'b11), wrAddr and rdAddr are used directly, and full and empty are both held at 0.
- R7: In queue and stack modes, full is 1 when 64 words are held and empty is 1 when none are held.
- R8: In queue and stack modes, a read while empty is ignored: no rdValid, and no pointer moves. A write while full, with no accepted read in the same cycle, is ignored.
- R9: rdValid and rdData appear in the cycle after an accepted read request. rdValid is 0 after any cycle with no accepted read.
- R10: A read and a write in the same cycle are resolved as follows. In queue mode, both are accepted even when the memory is full, and when it is empty only the write is accepted. In stack mode with a word held, the read returns the old top, the written word replaces it, and the depth is unchanged.
- R11: After reset, no words are held: empty=1, full=0 and rdValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | 00 queue, 01 stack, 1x random |
| widthSel | input | 3 | Number of active banks minus one |
| wrEn | input | 1 | Write request |
| wrAddr | input | 6 | Write address (random mode) |
| wrData | input | 32 | Decision vector to store |
| rdEn | input | 1 | Read request |
| rdAddr | input | 6 | Read address (random mode) |
| rdData | output | 32 | Read vector, zero above the configured width |
| rdValid | output | 1 | rdData holds the result of an accepted read |
| full | output | 1 | 64 words held (queue and stack modes) |
| empty | output | 1 | No words held (queue and stack modes) |
| bankEnable | output | 8 | Per-bank clock enable from the clock controller |

## Verification
A read and a write can fall in the same cycle, and that is where the address generator is most likely to go wrong. The bench provokes this in three places. It fills the queue to 64 words and then issues both requests together. It issues both requests together on an empty queue. It issues both requests together on a stack holding two words. In each case the bench judges the result by what comes out of the ports: the word returned in that cycle, whether full or empty changed, and the order in which the remaining words drain out afterwards.

// File: rtl/decmem_pkg.sv
package decmem_pkg;
  localparam int NUM_BANKS = 8;
  localparam int BANK_W    = 4;
  localparam int DEPTH     = 64;
  localparam int ADDR_W    = $clog2(DEPTH);
  localparam int CNT_W     = ADDR_W + 1;
  localparam int WORD_W    = NUM_BANKS * BANK_W;
  localparam int SEL_W     = $clog2(NUM_BANKS);

  typedef enum logic [1:0] {
    MODE_QUEUE = 2'b00,
    MODE_STACK = 2'b01,
    MODE_RAND  = 2'b10,
    MODE_RAND2 = 2'b11
  } memMode_e;

  // Strobes from the address generator to the bank array
  typedef struct packed {
    logic              wrStrobe;
    logic              rdStrobe;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
  } memStrobe_t;
endpackage

// File: rtl/decmem_bank.sv
module decmem_bank #(
  parameter int WIDTH = decmem_pkg::BANK_W,
  parameter int DEPTH = decmem_pkg::DEPTH,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             clkEn,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic             re,
  input  logic [AW-1:0]    ra,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  // clkEn stands in for a gated clock: nothing in the bank toggles when low
  always_ff @(posedge clk) begin
    if (clkEn) begin
      if (we) mem[wa] <= wd;
      if (re) q <= mem[ra];
    end
  end
endmodule

// File: rtl/decmem_ctrl.sv
module decmem_ctrl
  import decmem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] extWrAddr,
  input  logic [ADDR_W-1:0] extRdAddr,
  output memStrobe_t        strobe,
  output logic              full,
  output logic              empty
);
  logic [ADDR_W-1:0] headPtr, tailPtr, topIdx, fillLow;
  logic [CNT_W-1:0]  fillCnt;
  logic isRand, isStack, fullInt, emptyInt, rdOk, wrOk;

  assign isRand   = modeSel[1];
  assign isStack  = (memMode_e'(modeSel) == MODE_STACK);
  assign fullInt  = (fillCnt == CNT_W'(DEPTH));
  assign emptyInt = (fillCnt == '0);
  assign fillLow  = fillCnt[ADDR_W-1:0];
  assign topIdx   = fillLow - ADDR_W'(1);

  // a read frees a slot in the same cycle, so a write may follow it in
  assign rdOk = rdEn && (isRand || !emptyInt);
  assign wrOk = wrEn && (isRand || !fullInt || rdOk);

  always_comb begin
    strobe.wrStrobe = wrOk;
    strobe.rdStrobe = rdOk;
    if (isRand) begin
      strobe.wrAddr = extWrAddr;
      strobe.rdAddr = extRdAddr;
    end else if (isStack) begin
      strobe.rdAddr = topIdx;
      strobe.wrAddr = rdOk ? topIdx : fillLow;
    end else begin
      strobe.wrAddr = headPtr;
      strobe.rdAddr = tailPtr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      fillCnt <= '0;
    end else if (!isRand) begin
      if (!isStack) begin
        if (wrOk) headPtr <= headPtr + ADDR_W'(1);
        if (rdOk) tailPtr <= tailPtr + ADDR_W'(1);
      end
      if (wrOk && !rdOk)      fillCnt <= fillCnt + CNT_W'(1);
      else if (rdOk && !wrOk) fillCnt <= fillCnt - CNT_W'(1);
    end
  end

  assign full  = !isRand && fullInt;
  assign empty = !isRand && emptyInt;
endmodule

// File: rtl/decmem_datapath.sv
module decmem_datapath
  import decmem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  widthSel,
  input  memStrobe_t        strobe,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic [NUM_BANKS-1:0] bankEnable
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] bankQ;
    assign bankEnable[b] = (SEL_W'(b) <= widthSel);

    decmem_bank #(.WIDTH(BANK_W), .DEPTH(DEPTH)) u_bank (
      .clk  (clk),
      .clkEn(bankEnable[b]),
      .we   (strobe.wrStrobe),
      .wa   (strobe.wrAddr),
      .wd   (wrData[b*BANK_W +: BANK_W]),
      .re   (strobe.rdStrobe),
      .ra   (strobe.rdAddr),
      .q    (bankQ)
    );

    assign rdData[b*BANK_W +: BANK_W] = bankEnable[b] ? bankQ : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobe.rdStrobe;
  end
endmodule

// File: rtl/decision_mem.sv
module decision_mem
  import decmem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           modeSel,
  input  logic [SEL_W-1:0]     widthSel,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [WORD_W-1:0]    rdData,
  output logic                 rdValid,
  output logic                 full,
  output logic                 empty,
  output logic [NUM_BANKS-1:0] bankEnable
);
  memStrobe_t strobe;

  decmem_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .extWrAddr(wrAddr),
    .extRdAddr(rdAddr),
    .strobe   (strobe),
    .full     (full),
    .empty    (empty)
  );

  decmem_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .widthSel  (widthSel),
    .strobe    (strobe),
    .wrData    (wrData),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .bankEnable(bankEnable)
  );
endmodule

// File: rtl/decmem_checker.sv
module decmem_checker
  import decmem_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           modeSel,
  input logic [SEL_W-1:0]     widthSel,
  input logic                 rdEn,
  input logic [WORD_W-1:0]    rdData,
  input logic                 rdValid,
  input logic                 full,
  input logic                 empty,
  input logic [NUM_BANKS-1:0] bankEnable
);
  // R2: enabled banks form a run from bank 0, sized by widthSel
  p_gate_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(bankEnable) == int'(widthSel) + 1) && bankEnable[0]
    && ((bankEnable & (bankEnable + NUM_BANKS'(1))) == '0));

  // R3: nothing above the configured width leaks out
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdData >> (BANK_W * (int'(widthSel) + 1))) == '0);

  // R6: random mode never raises flags
  p_rand_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] |-> (!full && !empty));

  // R7: flags are exclusive
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  // R8: a full memory with no read stays full
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel[1] && full && !rdEn) |=> (full || (modeSel != $past(modeSel))));

  // R8: read from empty produces no data
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel[1] && empty && rdEn) |=> !rdValid);

  // R9: accepted read yields valid next cycle
  p_read_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (modeSel[1] || !empty)) |=> rdValid);

  // R9: no request, no valid
  p_idle_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);
endmodule

bind decision_mem decmem_checker u_chk (.*);

// File: tb/tb_decision_mem.sv
`timescale 1ns/1ps
module tb_decision_mem;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [2:0]  widthSel = 3'd7;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [5:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        rdValid, full, empty;
  logic [7:0]  bankEnable;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  decision_mem dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeOne(input logic [31:0] d, input logic [5:0] a);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; wrAddr = a;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readOne(input logic [5:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData; v = rdValid;
  endtask

  task automatic bothOne(input logic [31:0] wd, output logic [31:0] d, output logic v);
    @(negedge clk);
    wrEn = 1'b1; wrData = wd; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    d = rdData; v = rdValid;
  endtask

  function automatic logic [31:0] qWord(input int i);
    return 32'hC0DE0000 | 32'(i * 3 + 1);
  endfunction

  task automatic t_reset();
    doReset();
    check(empty === 1'b1, "R11 empty after reset", 32'(empty), 32'd1);
    check(full === 1'b0, "R11 full after reset", 32'(full), 32'd0);
    check(rdValid === 1'b0, "R11 rdValid after reset", 32'(rdValid), 32'd0);
    check(bankEnable === 8'hFF, "R2 all banks at width 7", 32'(bankEnable), 32'hFF);
  endtask

  task automatic t_queue_order();
    logic [31:0] d; logic v;
    modeSel = 2'b00; widthSel = 3'd7; doReset();
    for (int i = 0; i < 5; i++) writeOne(qWord(i), 6'd0);
    check(empty === 1'b0, "R7 not empty after writes", 32'(empty), 32'd0);
    for (int i = 0; i < 5; i++) begin
      readOne(6'd0, d, v);
      check(v === 1'b1, "R9 queue rdValid", 32'(v), 32'd1);
      check(d === qWord(i), "R4 queue order", d, qWord(i));
    end
    check(empty === 1'b1, "R7 empty after drain", 32'(empty), 32'd1);
  endtask

  task automatic t_queue_fill();
    logic [31:0] d; logic v;
    modeSel = 2'b00; doReset();
    for (int i = 0; i < 64; i++) writeOne(qWord(i), 6'd0);
    check(full === 1'b1, "R7 full at 64", 32'(full), 32'd1);
    writeOne(32'hDEADBEEF, 6'd0);
    check(full === 1'b1, "R8 full after dropped write", 32'(full), 32'd1);
    for (int i = 0; i < 64; i++) begin
      readOne(6'd0, d, v);
      check(d === qWord(i), "R8 R4 drain after dropped write", d, qWord(i));
    end
    check(empty === 1'b1, "R7 empty after 64 reads", 32'(empty), 32'd1);
    readOne(6'd0, d, v);
    check(v === 1'b0, "R8 read from empty ignored", 32'(v), 32'd0);
    check(empty === 1'b1, "R8 still empty", 32'(empty), 32'd1);
    // pointers have wrapped past 63; keep going
    for (int i = 0; i < 3; i++) writeOne(qWord(100 + i), 6'd0);
    for (int i = 0; i < 3; i++) begin
      readOne(6'd0, d, v);
      check(d === qWord(100 + i), "R4 order after wrap", d, qWord(100 + i));
    end
  endtask

  task automatic t_queue_simul();
    logic [31:0] d; logic v;
    modeSel = 2'b00; doReset();
    bothOne(32'h12345678, d, v);
    check(v === 1'b0, "R10 empty queue both: read ignored", 32'(v), 32'd0);
    check(empty === 1'b0, "R10 empty queue both: write taken", 32'(empty), 32'd0);
    readOne(6'd0, d, v);
    check(d === 32'h12345678, "R10 word from empty-both cycle", d, 32'h12345678);
    for (int i = 0; i < 64; i++) writeOne(qWord(i), 6'd0);
    bothOne(32'hFEEDF00D, d, v);
    check(v === 1'b1 && d === qWord(0), "R10 full queue both: read", d, qWord(0));
    check(full === 1'b1, "R10 full queue both: stays full", 32'(full), 32'd1);
    for (int i = 1; i < 64; i++) readOne(6'd0, d, v);
    readOne(6'd0, d, v);
    check(d === 32'hFEEDF00D, "R10 full queue both: write kept last", d, 32'hFEEDF00D);
  endtask

  task automatic t_stack();
    logic [31:0] d; logic v;
    modeSel = 2'b01; doReset();
    writeOne(32'hA, 6'd0); writeOne(32'hB, 6'd0); writeOne(32'hC, 6'd0);
    readOne(6'd0, d, v); check(d === 32'hC, "R5 pop newest", d, 32'hC);
    readOne(6'd0, d, v); check(d === 32'hB, "R5 pop second", d, 32'hB);
    readOne(6'd0, d, v); check(d === 32'hA, "R5 pop oldest", d, 32'hA);
    readOne(6'd0, d, v); check(v === 1'b0, "R8 pop empty stack ignored", 32'(v), 32'd0);
    writeOne(32'h11, 6'd0); writeOne(32'h22, 6'd0);
    bothOne(32'h33, d, v);
    check(v === 1'b1 && d === 32'h22, "R10 stack both returns old top", d, 32'h22);
    readOne(6'd0, d, v); check(d === 32'h33, "R10 stack both replaces top", d, 32'h33);
    readOne(6'd0, d, v); check(d === 32'h11, "R10 stack depth unchanged", d, 32'h11);
    check(empty === 1'b1, "R7 stack empty", 32'(empty), 32'd1);
    for (int i = 0; i < 64; i++) writeOne(qWord(i), 6'd0);
    check(full === 1'b1, "R7 stack full", 32'(full), 32'd1);
    writeOne(32'hBAD0BAD0, 6'd0);
    readOne(6'd0, d, v);
    check(d === qWord(63), "R8 push to full stack ignored", d, qWord(63));
  endtask

  task automatic t_random_width();
    logic [31:0] d; logic v;
    modeSel = 2'b10; widthSel = 3'd7; doReset();
    check(empty === 1'b0 && full === 1'b0, "R6 random flags low", {30'd0, full, empty}, 32'd0);
    writeOne(32'h0000_0505, 6'd5);
    writeOne(32'h0000_1717, 6'd17);
    readOne(6'd17, d, v); check(d === 32'h1717, "R6 random addr 17", d, 32'h1717);
    readOne(6'd5, d, v);  check(d === 32'h0505, "R6 random addr 5", d, 32'h0505);
    modeSel = 2'b11;
    readOne(6'd17, d, v); check(d === 32'h1717, "R6 mode 11 random", d, 32'h1717);
    check(empty === 1'b0 && full === 1'b0, "R6 mode 11 flags low", {30'd0, full, empty}, 32'd0);
    modeSel = 2'b10;
    writeOne(32'hA5A5_5A5A, 6'd9);
    widthSel = 3'd1;
    @(negedge clk);
    check(bankEnable === 8'h03, "R2 two banks enabled", 32'(bankEnable), 32'h03);
    readOne(6'd9, d, v); check(d === 32'h0000_005A, "R3 R1 8-bit read", d, 32'h5A);
    widthSel = 3'd0;
    writeOne(32'hFFFF_FFF3, 6'd9);
    widthSel = 3'd7;
    readOne(6'd9, d, v); check(d === 32'hA5A5_5A53, "R2 R1 gated banks hold", d, 32'hA5A55A53);
    widthSel = 3'd3;
    readOne(6'd9, d, v); check(d === 32'h0000_5A53, "R3 16-bit read", d, 32'h5A53);
    widthSel = 3'd7;
  endtask

  initial begin
    t_reset();
    t_queue_order();
    t_queue_fill();
    t_queue_simul();
    t_stack();
    t_random_width();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
      $finish;
    end
  end
endmodule